// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the hazard controller of an in-order five-stage integer pipeline (fetch, decode, execute, memory, write-back) with 32-bit instruction words. It looks at the instruction word and the class code held in the decode, execute, memory and write-back pipeline registers. It does two things. For the instruction in execute, it chooses where each ALU operand comes from. For the instruction in decode, it asks for a one-cycle hold when that instruction reads the result of a load that is still in execute.

Field positions use big-endian numbering: bit 0 is the most significant bit of the word. The register file, ALU, memories and branch resolution sit outside the block. The block is purely combinational, with no state of its own. The house style's state-machine structure therefore does not apply. Its "states" are the three operand sources (register file, memory-stage latch, write-back latch) and the two decode conditions (advance, hold with bubble). The pipeline registers outside the block move between these as the stall output is raised and dropped.

Class codes on every `*_kind` port: 0 = empty slot or bubble, 1 = register-register ALU, 2 = immediate ALU, 3 = load, 4 = store, 5 = branch.

Top module: `fwd_interlock`

## Requirements
- R1: The first source register is taken from big-endian bits 6..10 (word bits [25:21]). The second source register is taken from big-endian bits 11..15 (word bits [20:16]).
- R2: The destination is big-endian bits 16..20 (word bits [15:11]) for a register-register ALU op. It is big-endian bits 11..15 (word bits [20:16]) for a load or an immediate ALU op.
- R3: Select encoding is 2'b00 for the register file, 2'b01 for the memory-stage ALU result and 2'b10 for the write-back-stage value; 2'b11 is never produced. An ALU op in the memory stage whose destination equals an operand read by the execute instruction selects 2'b01.
- R4: An ALU op or a load in the write-back stage whose destination equals an operand read by the execute instruction selects 2'b10.
- R5: When both the memory and write-back stages match the same operand, the memory stage (2'b01) wins.
- R6: Stores, branches and empty slots never act as producers, whatever their fields hold.
- R7: Register 0 never matches, so it causes neither forwarding nor a stall.
- R8: A load in execute whose nonzero destination is read by the decode instruction raises `stall_req` for exactly one cycle. The dependent instruction then takes the loaded value through select 2'b10.
- R9: A load in the memory stage is never a bypass source, because its data is not yet available.
- R10: The second operand is read only by register-register ALU ops and by stores (the data to store), so it is forwarded only for those classes. The second field of an immediate op is ignored.
- R11: Only read-after-write dependences act. An instruction that writes, but does not read, a register a load in execute writes causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_insn | input | 32 | Instruction word in the decode register |
| id_kind | input | 3 | Class code of the decode instruction |
| ex_insn | input | 32 | Instruction word in the execute register |
| ex_kind | input | 3 | Class code of the execute instruction |
| mem_insn | input | 32 | Instruction word in the memory register |
| mem_kind | input | 3 | Class code of the memory instruction |
| wb_insn | input | 32 | Instruction word in the write-back register |
| wb_kind | input | 3 | Class code of the write-back instruction |
| fwd_a | output | 2 | Source select for the first ALU operand |
| fwd_b | output | 2 | Source select for the second ALU operand |
| stall_req | output | 1 | Hold fetch and decode and insert a bubble into execute |

## Verification
The bench runs instruction programs through a model pipeline that honours the stall output. It compares both selects and the stall every cycle against a behavioural model. It counts stall cycles per program: a load followed by three dependent ops must give exactly one. If a design took the destination from the wrong field for a class, selects would fire for unrelated registers or miss real dependences. If it let stores, branches or register 0 produce, spurious selects would appear. If it reversed the priority, it would hand the consumer stale write-back data. Direct stimulus also places a load in the memory stage under a dependent execute instruction, where a faulty design would select a value that does not exist yet.

// File: rtl/fwdi_pkg.sv
package fwdi_pkg;
    typedef enum logic [2:0] {
        K_NOP     = 3'd0,
        K_ALU_RR  = 3'd1,
        K_ALU_IMM = 3'd2,
        K_LOAD    = 3'd3,
        K_STORE   = 3'd4,
        K_BRANCH  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMSTG  = 2'b01,
        SEL_WBSTG   = 2'b10
    } sel_e;

    // producer filter variants for the destination decoder
    localparam int PROD_ANY  = 0;
    localparam int PROD_ALU  = 1;
    localparam int PROD_LOAD = 2;
endpackage

// File: rtl/fwdi_src_decode.sv
module fwdi_src_decode
    import fwdi_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int RA_W     = 5,
    parameter int SRC1_POS = 6,
    parameter int SRC2_POS = 11
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [2:0]        kind,
    output logic [RA_W-1:0]   src1,
    output logic [RA_W-1:0]   src2,
    output logic              rd1,
    output logic              rd2
);
    localparam int S1_LO = INSN_W - SRC1_POS - RA_W;
    localparam int S2_LO = INSN_W - SRC2_POS - RA_W;

    kind_e k;

    always_comb begin
        k    = kind_e'(kind);
        src1 = insn[S1_LO +: RA_W];
        src2 = insn[S2_LO +: RA_W];
        rd1  = 1'b0;
        rd2  = 1'b0;
        unique case (k)
            K_ALU_RR:                     begin rd1 = 1'b1; rd2 = 1'b1; end
            K_STORE:                      begin rd1 = 1'b1; rd2 = 1'b1; end
            K_ALU_IMM, K_LOAD, K_BRANCH:  rd1 = 1'b1;
            default:                      ;
        endcase
    end
endmodule

// File: rtl/fwdi_dst_decode.sv
module fwdi_dst_decode
    import fwdi_pkg::*;
#(
    parameter int INSN_W  = 32,
    parameter int RA_W    = 5,
    parameter int DLO_POS = 11,
    parameter int DHI_POS = 16,
    parameter int MODE    = PROD_ANY
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [2:0]        kind,
    output logic [RA_W-1:0]   dst,
    output logic              wr
);
    localparam int DL_LO = INSN_W - DLO_POS - RA_W;
    localparam int DR_LO = INSN_W - DHI_POS - RA_W;

    kind_e k;
    logic  cls_ok;

    always_comb begin
        k   = kind_e'(kind);
        dst = '0;
        unique case (k)
            K_ALU_RR:          dst = insn[DR_LO +: RA_W];
            K_ALU_IMM, K_LOAD: dst = insn[DL_LO +: RA_W];
            default:           dst = '0;
        endcase
    end

    generate
        if (MODE == PROD_ALU) begin : g_alu
            assign cls_ok = (k == K_ALU_RR) || (k == K_ALU_IMM);
        end else if (MODE == PROD_LOAD) begin : g_load
            assign cls_ok = (k == K_LOAD);
        end else begin : g_any
            assign cls_ok = (k == K_ALU_RR) || (k == K_ALU_IMM) || (k == K_LOAD);
        end
    endgenerate

    assign wr = cls_ok && (dst != '0);

    always_comb begin
        if (wr) begin
            p_writer_class_r6: assert (k != K_STORE && k != K_BRANCH && k != K_NOP);
        end
    end
endmodule

// File: rtl/fwdi_bypass.sv
module fwdi_bypass
    import fwdi_pkg::*;
#(
    parameter int RA_W = 5
) (
    input  logic [RA_W-1:0] src,
    input  logic            rd,
    input  logic [RA_W-1:0] mem_dst,
    input  logic            mem_wr,
    input  logic [RA_W-1:0] wb_dst,
    input  logic            wb_wr,
    output logic [1:0]      sel
);
    sel_e s;

    always_comb begin
        if (rd && mem_wr && (mem_dst == src))
            s = SEL_MEMSTG;
        else if (rd && wb_wr && (wb_dst == src))
            s = SEL_WBSTG;
        else
            s = SEL_REGFILE;
    end

    assign sel = s;

    always_comb begin
        p_sel_legal_r3: assert (sel != 2'b11);
        if (rd && mem_wr && wb_wr && mem_dst == src && wb_dst == src) begin
            p_young_first_r5: assert (sel == SEL_MEMSTG);
        end
    end
endmodule

// File: rtl/fwdi_interlock.sv
module fwdi_interlock #(
    parameter int RA_W = 5
) (
    input  logic [RA_W-1:0] id_src1,
    input  logic            id_rd1,
    input  logic [RA_W-1:0] id_src2,
    input  logic            id_rd2,
    input  logic [RA_W-1:0] ld_dst,
    input  logic            ld_wr,
    output logic            stall
);
    logic hit1, hit2;

    always_comb begin
        hit1  = id_rd1 && (id_src1 == ld_dst);
        hit2  = id_rd2 && (id_src2 == ld_dst);
        stall = ld_wr && (hit1 || hit2);
    end

    always_comb begin
        if (stall) begin
            p_stall_nonzero_r7: assert (ld_dst != '0);
        end
    end
endmodule

// File: rtl/fwd_interlock.sv
module fwd_interlock
    import fwdi_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int RA_W     = 5,
    parameter int SRC1_POS = 6,
    parameter int SRC2_POS = 11,
    parameter int DRR_POS  = 16
) (
    input  logic [INSN_W-1:0] id_insn,
    input  logic [2:0]        id_kind,
    input  logic [INSN_W-1:0] ex_insn,
    input  logic [2:0]        ex_kind,
    input  logic [INSN_W-1:0] mem_insn,
    input  logic [2:0]        mem_kind,
    input  logic [INSN_W-1:0] wb_insn,
    input  logic [2:0]        wb_kind,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              stall_req
);
    localparam int NCONS = 2;  // consumers: decode, execute
    localparam int NPROD = 3;  // producers: execute, memory, write-back

    logic [INSN_W-1:0] c_insn [NCONS];
    logic [2:0]        c_kind [NCONS];
    logic [RA_W-1:0]   c_s1   [NCONS];
    logic [RA_W-1:0]   c_s2   [NCONS];
    logic              c_r1   [NCONS];
    logic              c_r2   [NCONS];

    logic [INSN_W-1:0] p_insn [NPROD];
    logic [2:0]        p_kind [NPROD];
    logic [RA_W-1:0]   p_dst  [NPROD];
    logic              p_wr   [NPROD];

    assign c_insn[0] = id_insn;  assign c_kind[0] = id_kind;
    assign c_insn[1] = ex_insn;  assign c_kind[1] = ex_kind;
    assign p_insn[0] = ex_insn;  assign p_kind[0] = ex_kind;
    assign p_insn[1] = mem_insn; assign p_kind[1] = mem_kind;
    assign p_insn[2] = wb_insn;  assign p_kind[2] = wb_kind;

    genvar gi;
    generate
        for (gi = 0; gi < NCONS; gi++) begin : g_src
            fwdi_src_decode #(
                .INSN_W(INSN_W), .RA_W(RA_W),
                .SRC1_POS(SRC1_POS), .SRC2_POS(SRC2_POS)
            ) u_src (
                .insn(c_insn[gi]), .kind(c_kind[gi]),
                .src1(c_s1[gi]), .src2(c_s2[gi]),
                .rd1(c_r1[gi]), .rd2(c_r2[gi])
            );
        end
        for (gi = 0; gi < NPROD; gi++) begin : g_dst
            // execute: loads only; memory: ALU only; write-back: any writer
            fwdi_dst_decode #(
                .INSN_W(INSN_W), .RA_W(RA_W),
                .DLO_POS(SRC2_POS), .DHI_POS(DRR_POS),
                .MODE(gi == 0 ? PROD_LOAD : (gi == 1 ? PROD_ALU : PROD_ANY))
            ) u_dst (
                .insn(p_insn[gi]), .kind(p_kind[gi]),
                .dst(p_dst[gi]), .wr(p_wr[gi])
            );
        end
    endgenerate

    fwdi_bypass #(.RA_W(RA_W)) u_byp_a (
        .src(c_s1[1]), .rd(c_r1[1]),
        .mem_dst(p_dst[1]), .mem_wr(p_wr[1]),
        .wb_dst(p_dst[2]), .wb_wr(p_wr[2]),
        .sel(fwd_a)
    );

    fwdi_bypass #(.RA_W(RA_W)) u_byp_b (
        .src(c_s2[1]), .rd(c_r2[1]),
        .mem_dst(p_dst[1]), .mem_wr(p_wr[1]),
        .wb_dst(p_dst[2]), .wb_wr(p_wr[2]),
        .sel(fwd_b)
    );

    fwdi_interlock #(.RA_W(RA_W)) u_lock (
        .id_src1(c_s1[0]), .id_rd1(c_r1[0]),
        .id_src2(c_s2[0]), .id_rd2(c_r2[0]),
        .ld_dst(p_dst[0]), .ld_wr(p_wr[0]),
        .stall(stall_req)
    );

    always_comb begin
        if (stall_req) begin
            p_stall_only_load_r8: assert (ex_kind == K_LOAD);
        end
        if (fwd_a == SEL_MEMSTG || fwd_b == SEL_MEMSTG) begin
            p_mem_src_alu_r9: assert (mem_kind == K_ALU_RR || mem_kind == K_ALU_IMM);
        end
        if (ex_kind == K_ALU_IMM || ex_kind == K_LOAD || ex_kind == K_BRANCH) begin
            p_imm_b_ignored_r10: assert (fwd_b == SEL_REGFILE);
        end
        if (ex_kind != K_NOP && ex_insn[INSN_W-SRC1_POS-1 -: RA_W] == '0) begin
            p_zero_no_fwd_r7: assert (fwd_a == SEL_REGFILE);
        end
    end
endmodule

// File: tb/test_fwd_interlock.sv
module test_fwd_interlock;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] id_insn = '0, ex_insn = '0, mem_insn = '0, wb_insn = '0;
    logic [2:0]  id_kind = '0, ex_kind = '0, mem_kind = '0, wb_kind = '0;
    logic [1:0]  fwd_a, fwd_b;
    logic        stall_req;

    fwd_interlock i_fwd_interlock (
        .id_insn(id_insn), .id_kind(id_kind), .ex_insn(ex_insn), .ex_kind(ex_kind),
        .mem_insn(mem_insn), .mem_kind(mem_kind), .wb_insn(wb_insn), .wb_kind(wb_kind),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_req(stall_req)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    localparam int NOP = 0, RR = 1, IMM = 2, LD = 3, ST = 4, BR = 5;

    // word from big-endian fields: a at 6..10, b at 11..15, c at 16..20
    function automatic logic [34:0] mk(int k, int a, int b, int c);
        logic [31:0] w;
        w = 32'h0;
        w[25:21] = a[4:0];
        w[20:16] = b[4:0];
        w[15:11] = c[4:0];
        w[10:0]  = 11'h5a5;
        return {k[2:0], w};
    endfunction

    function automatic int dst_of(int k, logic [31:0] w);
        if (k == RR) return int'(w[15:11]);
        if (k == IMM || k == LD) return int'(w[20:16]);
        return 0;
    endfunction

    function automatic int sel_ref(int src, bit rd, int mk_, logic [31:0] mw, int wk, logic [31:0] ww);
        if (!rd || src == 0) return 0;
        if ((mk_ == RR || mk_ == IMM) && dst_of(mk_, mw) == src) return 1;
        if ((wk == RR || wk == IMM || wk == LD) && dst_of(wk, ww) == src) return 2;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_now(string tag, output bit st);
        int ek, xk, ea, eb, d;
        bit ra, rb, es;
        logic [31:0] xw;
        xk = int'(ex_kind); xw = ex_insn;
        ra = (xk != NOP);
        rb = (xk == RR || xk == ST);
        ea = sel_ref(int'(xw[25:21]), ra, int'(mem_kind), mem_insn, int'(wb_kind), wb_insn);
        eb = sel_ref(int'(xw[20:16]), rb, int'(mem_kind), mem_insn, int'(wb_kind), wb_insn);
        ek = int'(id_kind);
        d = dst_of(xk, xw);
        es = (xk == LD) && d != 0 &&
             ((ek != NOP && int'(id_insn[25:21]) == d) ||
              ((ek == RR || ek == ST) && int'(id_insn[20:16]) == d));
        chk(tag, int'(fwd_a), ea, "fwd_a");
        chk(tag, int'(fwd_b), eb, "fwd_b");
        chk(tag, int'(stall_req), int'(es), "stall_req");
        st = es;
    endtask

    task automatic run_prog(string tag, logic [34:0] prog[$], int exp_stalls);
        int stalls = 0;
        logic [34:0] nopw;
        nopw = '0;
        {id_kind, id_insn} = nopw; {ex_kind, ex_insn} = nopw;
        {mem_kind, mem_insn} = nopw; {wb_kind, wb_insn} = nopw;
        if (prog.size() > 0) {id_kind, id_insn} = prog.pop_front();
        for (int cyc = 0; cyc < 40; cyc++) begin
            bit st;
            @(negedge clk);
            #1;
            compare_now(tag, st);
            if (st) stalls++;
            {wb_kind, wb_insn} = {mem_kind, mem_insn};
            {mem_kind, mem_insn} = {ex_kind, ex_insn};
            if (st) begin
                {ex_kind, ex_insn} = nopw;
            end else begin
                {ex_kind, ex_insn} = {id_kind, id_insn};
                {id_kind, id_insn} = (prog.size() > 0) ? prog.pop_front() : nopw;
            end
        end
        chk(tag, stalls, exp_stalls, "stall cycle count (R8)");
    endtask

    task automatic direct(string tag, logic [34:0] i_, logic [34:0] x_, logic [34:0] m_, logic [34:0] w_,
                          int ea, int eb, int es);
        @(negedge clk);
        {id_kind, id_insn} = i_; {ex_kind, ex_insn} = x_;
        {mem_kind, mem_insn} = m_; {wb_kind, wb_insn} = w_;
        #1;
        chk(tag, int'(fwd_a), ea, "fwd_a");
        chk(tag, int'(fwd_b), eb, "fwd_b");
        chk(tag, int'(stall_req), es, "stall_req");
    endtask

    initial begin
        logic [34:0] q[$];
        // idle pipeline: every select on the register file (R3)
        @(negedge clk); #1;
        chk("R3", int'(fwd_a), 0, "idle fwd_a");
        chk("R3", int'(fwd_b), 0, "idle fwd_b");
        chk("R3", int'(stall_req), 0, "idle stall");

        // R8/R4: load then three dependents, exactly one stall
        q = {mk(LD,2,1,0), mk(RR,1,5,4), mk(RR,1,7,6), mk(RR,9,1,8)};
        run_prog("R8", q, 1);

        // R3/R4/R5: ALU chain, memory stage priority
        q = {mk(RR,2,3,1), mk(IMM,4,1,0), mk(RR,1,1,5), mk(RR,5,1,8)};
        run_prog("R5", q, 0);

        // R6: stores and branches with fields equal to later sources
        q = {mk(ST,2,3,0), mk(BR,3,4,3), mk(RR,3,3,6), mk(RR,4,3,7)};
        run_prog("R6", q, 0);

        // R7: writes to register 0 never produce
        q = {mk(RR,2,3,0), mk(RR,0,0,5), mk(LD,2,0,0), mk(RR,0,0,6)};
        run_prog("R7", q, 0);

        // R10: immediate op second field ignored; store data forwarded and interlocked
        q = {mk(RR,2,3,1), mk(IMM,4,1,0), mk(RR,3,3,7), mk(ST,2,7,0),
             mk(LD,2,9,0), mk(ST,4,9,0)};
        run_prog("R10", q, 1);

        // R11: write-after-write after a load causes no stall
        q = {mk(LD,2,4,0), mk(IMM,6,4,0), mk(RR,3,5,4)};
        run_prog("R11", q, 0);

        // R1/R2: field positions, load reaches consumer via write-back gap
        q = {mk(LD,3,8,0), mk(RR,2,3,9), mk(RR,8,8,10), mk(RR,11,12,8), mk(RR,8,10,1)};
        run_prog("R2", q, 0);

        // R9: load in memory stage is not a bypass source
        direct("R9", mk(NOP,0,0,0), mk(RR,1,1,4), mk(LD,2,1,0), mk(NOP,0,0,0), 0, 0, 0);
        // R9 with an older ALU producer of same register in write-back
        direct("R9", mk(NOP,0,0,0), mk(RR,1,2,4), mk(LD,2,1,0), mk(RR,3,3,1), 2, 0, 0);
        // R1: source 1 in bits 6..10, source 2 in bits 11..15
        direct("R1", mk(NOP,0,0,0), mk(RR,12,13,4), mk(RR,0,0,13), mk(RR,0,0,12), 2, 1, 0);
        // R2: rr destination taken from bits 16..20, not bits 11..15
        direct("R2", mk(NOP,0,0,0), mk(RR,6,7,4), mk(RR,1,6,9), mk(NOP,0,0,0), 0, 0, 0);
        // R6: branch in write-back never forwards
        direct("R6", mk(NOP,0,0,0), mk(RR,6,7,4), mk(NOP,0,0,0), mk(BR,6,7,7), 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule